// File: doc/BRIEF.md
# Suspend Clock-Stop Sequencer

This block steps a processor core into and out of suspend. An active-low suspend request pin starts the entry. The block first gates the core clock enable. In the deeper mode it then gates the memory/display controller clock enable. After a fixed settling window it drives an active-low acknowledge. When the request pin goes high again, the enables come back in the reverse order, and the acknowledge is released only once both are on again.

A one-bit mode register, written through a simple write strobe, picks the flavour. Mode 0 keeps the memory and display clocks running through suspend, so the external clock must stay up. Mode 1 stops every internal clock, and the external clock may be removed once acknowledge is low. A status output tells the board whether the external clock must keep running. Clock gating is modelled only as enable outputs. The request pin passes through a synchronizer of `SYNC_STAGES` flops. The settling window is `SETTLE_CYCLES`, clamped to a minimum of 2.

Top module: `susp_clk_ctrl`

## Requirements
- R1: During and after reset, both clock enables are 1, `susp_ack_no` is 1 and `ext_clk_keep_o` is 1.
- R2: With the block running, `core_clk_en_o` falls on the (SYNC_STAGES+1)-th rising edge after `susp_req_ni` is first sampled low. Until then no output changes, and on that edge the other outputs are unchanged.
- R3: In mode 1, `mem_clk_en_o` falls one cycle after `core_clk_en_o` falls.
- R4: In mode 0, `mem_clk_en_o` stays 1 through the whole suspend entry, hold and exit.
- R5: `susp_ack_no` falls SETTLE_CYCLES cycles after `core_clk_en_o` falls, with both enables already in their suspended values.
- R6: `ext_clk_keep_o` is 0 only while acknowledge is asserted in a mode-1 suspend. It falls with acknowledge and returns to 1 when the memory enable is restored. In mode 0 it stays 1.
- R7: With the block suspended, `mem_clk_en_o` is 1 on the (SYNC_STAGES+1)-th rising edge after `susp_req_ni` is sampled high. `core_clk_en_o` rises one cycle later, and `susp_ack_no` rises one cycle after that.
- R8: The mode bit is written from `cfg_deep_i` on a clock edge where `cfg_we_i` is 1, and is held otherwise. The value in force on the edge where suspend entry starts governs that whole suspend. A write made during suspend takes effect only at the next entry.
- R9: Once the core enable has dropped, entry runs to completion: acknowledge is asserted even if the request pin is released during the settling window, and the normal exit then follows.
- R10: `mem_clk_en_o` is never 0 while `core_clk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_req_ni | input | 1 | Suspend request, active low, asynchronous to clk_i |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_deep_i | input | 1 | Mode value to write: 0 keeps memory/display clocks, 1 stops all |
| core_clk_en_o | output | 1 | Core clock domain enable |
| mem_clk_en_o | output | 1 | Memory/display controller clock domain enable |
| susp_ack_no | output | 1 | Suspend acknowledge, active low |
| ext_clk_keep_o | output | 1 | 1 while the external clock must keep running |

## Verification
The bench builds the block with SYNC_STAGES=2 and SETTLE_CYCLES=3. Every edge of entry and exit then falls within a few cycles, so all outputs are compared against an arithmetic timeline on every single cycle. It sweeps both modes against hold lengths of zero to three cycles. It also covers a mode write during suspend, a write with the strobe low, and a request released inside the settling window. These parameters separate the synchronizer delay, the mode-1 memory drop and the settling count, so an off-by-one in any of them shows up in a different cycle.

// File: rtl/susp_pkg.sv
`timescale 1ns/1ps
package susp_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SETTLE,
    ST_SUSP,
    ST_WAKE_CORE,
    ST_RELEASE
  } susp_state_e;

  function automatic int unsigned settle_min(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction
endpackage

// File: rtl/susp_req_sync.sv
`timescale 1ns/1ps
module susp_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic req_o
);
  // active-high request, resets to idle
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= ~req_ni;
      end
      assign req_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], ~req_ni};
      end
      assign req_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/susp_mode_reg.sv
`timescale 1ns/1ps
module susp_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic deep_i,
  output logic deep_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   deep_o <= 1'b0;
    else if (we_i) deep_o <= deep_i;
  end
endmodule

// File: rtl/susp_seq.sv
`timescale 1ns/1ps
module susp_seq
  import susp_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic deep_i,
  output logic core_en_o,
  output logic mem_en_o,
  output logic ack_no,
  output logic keep_o
);
  localparam int unsigned SETTLE_EFF = settle_min(SETTLE_CYCLES);
  localparam int unsigned CW         = $clog2(SETTLE_EFF + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_EFF - 1);

  susp_state_e    state_q;
  logic [CW-1:0]  cnt_q;
  logic           deep_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      deep_lat_q <= 1'b0;
      core_en_o  <= 1'b1;
      mem_en_o   <= 1'b1;
      ack_no     <= 1'b1;
      keep_o     <= 1'b1;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (req_i) begin
            state_q    <= ST_SETTLE;
            core_en_o  <= 1'b0;
            cnt_q      <= '0;
            deep_lat_q <= deep_i;   // mode frozen for this suspend
          end
        end
        ST_SETTLE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0) mem_en_o <= ~deep_lat_q;
          if (cnt_q == CNT_LAST) begin
            ack_no  <= 1'b0;
            keep_o  <= ~deep_lat_q;
            state_q <= ST_SUSP;
          end
        end
        ST_SUSP: begin
          if (!req_i) begin
            mem_en_o <= 1'b1;
            keep_o   <= 1'b1;
            state_q  <= ST_WAKE_CORE;
          end
        end
        ST_WAKE_CORE: begin
          core_en_o <= 1'b1;
          state_q   <= ST_RELEASE;
        end
        ST_RELEASE: begin
          ack_no  <= 1'b1;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/susp_clk_ctrl.sv
`timescale 1ns/1ps
module susp_clk_ctrl #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic susp_req_ni,
  input  logic cfg_we_i,
  input  logic cfg_deep_i,
  output logic core_clk_en_o,
  output logic mem_clk_en_o,
  output logic susp_ack_no,
  output logic ext_clk_keep_o
);
  logic req_sync;
  logic deep_q;

  susp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (susp_req_ni),
    .req_o  (req_sync)
  );

  susp_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .deep_i (cfg_deep_i),
    .deep_o (deep_q)
  );

  susp_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_sync),
    .deep_i    (deep_q),
    .core_en_o (core_clk_en_o),
    .mem_en_o  (mem_clk_en_o),
    .ack_no    (susp_ack_no),
    .keep_o    (ext_clk_keep_o)
  );
endmodule

// File: rtl/susp_clk_ctrl_chk.sv
`timescale 1ns/1ps
module susp_clk_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic core_clk_en_o,
  input logic mem_clk_en_o,
  input logic susp_ack_no,
  input logic ext_clk_keep_o
);
  assert_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_clk_en_o |-> !core_clk_en_o);

  assert_ack_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_ack_no) |-> !core_clk_en_o && $past(!core_clk_en_o));

  assert_ack_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_ack_no) |-> core_clk_en_o && mem_clk_en_o && ext_clk_keep_o);

  assert_keep_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_clk_keep_o |-> !susp_ack_no && !mem_clk_en_o && !core_clk_en_o);

  assert_core_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> susp_ack_no && mem_clk_en_o && ext_clk_keep_o);
endmodule

bind susp_clk_ctrl susp_clk_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_clk_en_o  (core_clk_en_o),
  .mem_clk_en_o   (mem_clk_en_o),
  .susp_ack_no    (susp_ack_no),
  .ext_clk_keep_o (ext_clk_keep_o)
);

// File: tb/tb_susp_clk_ctrl.sv
`timescale 1ns/1ps
module tb_susp_clk_ctrl;
  localparam int SYNC = 2;
  localparam int SETTLE = 3;
  localparam int L = SYNC + 1;
  localparam int S = SETTLE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic we = 1'b0;
  logic deep = 1'b0;
  logic core_en, mem_en, ack_n, keep;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  susp_clk_ctrl #(.SYNC_STAGES(SYNC), .SETTLE_CYCLES(SETTLE)) dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .susp_req_ni    (req_n),
    .cfg_we_i       (we),
    .cfg_deep_i     (deep),
    .core_clk_en_o  (core_en),
    .mem_clk_en_o   (mem_en),
    .susp_ack_no    (ack_n),
    .ext_clk_keep_o (keep)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic c, input logic m,
                     input logic a, input logic k);
    total++;
    if ({core_en, mem_en, ack_n, keep} !== {c, m, a, k}) begin
      fails++;
      $display("FAIL %s t=%0t core/mem/ack_n/keep act=%b%b%b%b exp=%b%b%b%b",
               tag, $time, core_en, mem_en, ack_n, keep, c, m, a, k);
    end
  endtask

  task automatic write_mode(input logic v);
    we = 1'b1; deep = v; step(); we = 1'b0; deep = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 entry timeline
  task automatic enter(input logic d);
    req_n = 1'b0;
    for (int k = 1; k <= L + S; k++) begin
      step();
      chk("R2_R3_R4_R5_R6 entry", k < L, !(d && k >= L + 1), k < L + S, !(d && k >= L + S));
    end
  endtask

  task automatic hold(input logic d, input int n);
    for (int i = 0; i < n; i++) begin
      step();
      chk("R4_R6 hold", 1'b0, !d, 1'b0, !d);
    end
  endtask

  // R7 exit timeline
  task automatic leave(input logic d);
    req_n = 1'b1;
    for (int m = 1; m <= L + 3; m++) begin
      step();
      chk("R7 exit", m >= L + 1, (m >= L) || !d, m >= L + 2, (m >= L) || !d);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step();
    chk("R1 in reset", 1'b1, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    step(); step();
    chk("R1 after reset", 1'b1, 1'b1, 1'b1, 1'b1);

    // sweep both modes and hold lengths
    for (int md = 0; md < 2; md++) begin
      for (int h = 0; h < 4; h++) begin
        write_mode(md[0]);
        enter(md[0]);
        hold(md[0], h);
        leave(md[0]);
        step();
        chk("R1 back to run", 1'b1, 1'b1, 1'b1, 1'b1);
      end
    end

    // R8: write during suspend has no effect until next entry
    write_mode(1'b1);
    enter(1'b1);
    write_mode(1'b0);
    chk("R8 write during suspend", 1'b0, 1'b0, 1'b0, 1'b0);
    hold(1'b1, 2);
    leave(1'b1);
    enter(1'b0);
    hold(1'b0, 1);
    leave(1'b0);

    // R8: strobe low ignores data
    we = 1'b0; deep = 1'b1; step(); deep = 1'b0;
    enter(1'b0);
    leave(1'b0);

    // R9: request released inside the settling window, mode 1
    write_mode(1'b1);
    req_n = 1'b0;
    for (int k = 1; k <= L + S + 3; k++) begin
      step();
      if (k == L) req_n = 1'b1;
      chk("R9 early release", (k < L) || (k >= L + S + 2),
          !((k >= L + 1) && (k < L + S + 1)),
          (k < L + S) || (k >= L + S + 3),
          !((k >= L + S) && (k < L + S + 1)));
    end
    step();
    chk("R1 idle end", 1'b1, 1'b1, 1'b1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule